// File: doc/BRIEF.md
# Receive Address Filter and Status Queue

This block sits behind an Ethernet receive MAC. It watches the byte stream of each frame, which is framed by start and end markers, and takes the first six bytes as the destination address. A 4-bit filter mode and a 48-bit station address decide whether the frame is accepted. The mode can accept the station's own address, group addresses, the all-ones broadcast address, or every frame. The MAC reports overrun, CRC, dribble and alignment problems as flags on the last byte of the frame. Payload storage and CRC computation happen elsewhere.

For every accepted frame the block builds a 16-bit status word. The word holds the byte count, an error code, an error flag and an empty flag. The word is placed in a small first-in first-out queue. The host reads the oldest word on `status_o` and retires it with a one-cycle discard strobe. When the queue holds nothing, the output shows only the empty flag.

Top module: `rx_addr_filter_stat`

## Requirements
- R1: With filter bit 0 set, a frame whose destination equals `station_addr_i` is accepted. The first byte on the wire is compared with bits 47:40.
- R2: With filter bit 1 set, a frame is accepted when bit 0 of its first destination byte is 1 and the destination is not all ones. A broadcast frame is not accepted through this bit.
- R3: With filter bit 2 set, a frame whose destination is all ones is accepted.
- R4: With filter bit 3 set, every frame of at least six bytes is accepted, whatever its destination.
- R5: A frame that no enabled filter bit accepts adds no status word. A frame shorter than six bytes never adds one.
- R6: Status bits 10:0 carry the number of bytes between start and end marker. The count saturates at 2047.
- R7: Status bit 14 is set when an error applies, and bits 13:11 then give its code: 0 overrun, 1 oversize (more than 1514 bytes), 2 dribble, 3 runt (fewer than 60 bytes), 4 alignment, 5 CRC. A frame with no error has bits 14:11 at zero.
- R8: When several errors apply, the code reported is the first of: overrun, CRC, oversize, runt, alignment, dribble.
- R9: While the queue is empty, `status_o` reads 16'h8000. Otherwise bit 15 is 0.
- R10: A discard strobe removes the oldest word, so words leave in arrival order. A discard on an empty queue changes nothing.
- R11: The queue holds DEPTH (default 4) words. A word produced while the queue is full, with no discard in that cycle, is dropped.
- R12: A discard and a new word in the same cycle both take effect.
- R13: The status word of a frame appears on `status_o` in the cycle after the clock edge that takes the end-marked byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | Byte on `rx_data_i` is valid |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| rx_data_i | input | 8 | Frame byte |
| rx_overrun_i | input | 1 | Overrun flag, sampled with the last byte |
| rx_crc_err_i | input | 1 | CRC failure flag, sampled with the last byte |
| rx_dribble_i | input | 1 | Dribble-bit flag, sampled with the last byte |
| rx_align_err_i | input | 1 | Alignment flag, sampled with the last byte |
| filt_mode_i | input | 4 | Accept enables: 0 own, 1 group, 2 broadcast, 3 all |
| station_addr_i | input | 48 | Station address, first wire byte in 47:40 |
| discard_i | input | 1 | Retire the oldest status word |
| status_o | output | 16 | Oldest status word, or 16'h8000 when empty |

## Verification
A new status word can enter the queue in the same cycle as the host's discard strobe retires the oldest one. The bench sets this up by leaving one word queued and then raising the discard strobe during the end-marked byte of the next accepted frame. It judges the result at the ports. After that edge, `status_o` must already show the new frame's length. One more discard must then leave the queue empty. This shows that the push was neither lost nor counted twice.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [2:0] {
      ERR_OVERRUN  = 3'd0,
      ERR_OVERSIZE = 3'd1,
      ERR_DRIBBLE  = 3'd2,
      ERR_RUNT     = 3'd3,
      ERR_ALIGN    = 3'd4,
      ERR_CRC      = 3'd5
   } rx_err_e;

   typedef struct packed {
      logic        empty;
      logic        err;
      rx_err_e     code;
      logic [10:0] len;
   } rx_stat_t;

   localparam rx_stat_t STAT_EMPTY = '{empty: 1'b1, err: 1'b0, code: ERR_OVERRUN, len: 11'd0};

   localparam int FB_INDIV   = 0;
   localparam int FB_MCAST   = 1;
   localparam int FB_BCAST   = 2;
   localparam int FB_PROMISC = 3;

   localparam int ADDR_BYTES = 6;

endpackage

// File: rtl/rxf_frame_track.sv
module rxf_frame_track #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid_i,
   input  logic             rx_sof_i,
   input  logic             rx_eof_i,
   input  logic [7:0]       rx_data_i,
   output logic             done_o,
   output logic             hdr_ok_o,
   output logic [LEN_W-1:0] len_o,
   output logic [47:0]      dest_o
);
   import rxf_pkg::*;

   localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};

   logic             in_q;
   logic [LEN_W-1:0] cnt_q;
   logic [47:0]      da_q;

   logic             take;
   logic [LEN_W-1:0] idx;
   logic [LEN_W-1:0] len_nxt;
   logic [47:0]      da_nxt;

   assign take    = rx_valid_i && (rx_sof_i || in_q);
   assign idx     = rx_sof_i ? '0 : cnt_q;
   assign len_nxt = (idx == LEN_SAT) ? idx : idx + 1'b1;

   always_comb begin
      da_nxt = rx_sof_i ? '0 : da_q;
      for (int b = 0; b < ADDR_BYTES; b++) begin
         if (idx == LEN_W'(b)) da_nxt[47-8*b -: 8] = rx_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q  <= 1'b0;
         cnt_q <= '0;
         da_q  <= '0;
      end else if (take) begin
         in_q  <= !rx_eof_i;
         cnt_q <= len_nxt;
         da_q  <= da_nxt;
      end
   end

   assign done_o   = take && rx_eof_i;
   assign hdr_ok_o = len_nxt >= LEN_W'(ADDR_BYTES);
   assign len_o    = len_nxt;
   assign dest_o   = da_nxt;

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match (
   input  logic [3:0]  filt_i,
   input  logic [47:0] station_i,
   input  logic [47:0] dest_i,
   output logic        accept_o
);
   import rxf_pkg::*;

   logic is_bcast;
   logic is_mcast;
   logic is_own;

   assign is_bcast = &dest_i;
   assign is_mcast = dest_i[40] && !is_bcast;
   assign is_own   = (dest_i == station_i);

   assign accept_o = filt_i[FB_PROMISC]
                   | (filt_i[FB_BCAST] & is_bcast)
                   | (filt_i[FB_MCAST] & is_mcast)
                   | (filt_i[FB_INDIV] & is_own);

endmodule

// File: rtl/rxf_err_encode.sv
module rxf_err_encode #(
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1514,
   parameter int MIN_LEN = 60
) (
   input  logic [LEN_W-1:0]  len_i,
   input  logic              overrun_i,
   input  logic              crc_i,
   input  logic              dribble_i,
   input  logic              align_i,
   output rxf_pkg::rx_stat_t stat_o
);
   import rxf_pkg::*;

   logic too_long;
   logic too_short;

   assign too_long  = len_i > LEN_W'(MAX_LEN);
   assign too_short = len_i < LEN_W'(MIN_LEN);

   always_comb begin
      stat_o.empty = 1'b0;
      stat_o.len   = 11'(len_i);
      stat_o.err   = 1'b1;
      if (overrun_i)      stat_o.code = ERR_OVERRUN;
      else if (crc_i)     stat_o.code = ERR_CRC;
      else if (too_long)  stat_o.code = ERR_OVERSIZE;
      else if (too_short) stat_o.code = ERR_RUNT;
      else if (align_i)   stat_o.code = ERR_ALIGN;
      else if (dribble_i) stat_o.code = ERR_DRIBBLE;
      else begin
         stat_o.code = ERR_OVERRUN;
         stat_o.err  = 1'b0;
      end
   end

endmodule

// File: rtl/rxf_stat_queue.sv
module rxf_stat_queue #(
   parameter int DEPTH = 4,
   parameter int W     = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [W-1:0]     push_data_i,
   input  logic             pop_i,
   output logic [W-1:0]     head_o,
   output logic             empty_o,
   output logic [LVL_W-1:0] level_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

   logic [W-1:0]     mem [DEPTH];
   logic [AW-1:0]    wr_q, rd_q, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] lvl_q;
   logic             do_push, do_pop;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign do_pop  = pop_i && (lvl_q != '0);
   assign do_push = push_i && ((lvl_q != LVL_FULL) || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= push_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

   assign head_o  = mem[rd_q];
   assign empty_o = (lvl_q == '0);
   assign level_o = lvl_q;

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_FULL);

   // R11
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && lvl_q == LVL_FULL) |=> (lvl_q == LVL_FULL));

   // R10
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && lvl_q == '0) |=> (lvl_q == '0));

   // R12
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && lvl_q != '0) |=> $stable(lvl_q));

endmodule

// File: rtl/rx_addr_filter_stat.sv
module rx_addr_filter_stat #(
   parameter int LEN_W   = 11,
   parameter int MAX_LEN = 1514,
   parameter int MIN_LEN = 60,
   parameter int DEPTH   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid_i,
   input  logic        rx_sof_i,
   input  logic        rx_eof_i,
   input  logic [7:0]  rx_data_i,
   input  logic        rx_overrun_i,
   input  logic        rx_crc_err_i,
   input  logic        rx_dribble_i,
   input  logic        rx_align_err_i,
   input  logic [3:0]  filt_mode_i,
   input  logic [47:0] station_addr_i,
   input  logic        discard_i,
   output logic [15:0] status_o
);
   import rxf_pkg::*;

   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int STAT_W = $bits(rx_stat_t);

   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("DEPTH must be at least 4");
      end
      if (LEN_W != 11) begin : g_bad_len_w
         $error("LEN_W must match the 11-bit length field");
      end
      if (MIN_LEN >= MAX_LEN || MAX_LEN >= (1 << LEN_W)) begin : g_bad_limits
         $error("length limits out of range");
      end
   endgenerate

   logic             f_done, f_hdr_ok, f_accept, q_push, q_empty;
   logic [LEN_W-1:0] f_len;
   logic [47:0]      f_dest;
   rx_stat_t         f_stat;
   logic [STAT_W-1:0] q_head;
   logic [LVL_W-1:0] q_level;

   rxf_frame_track #(.LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid_i (rx_valid_i),
      .rx_sof_i   (rx_sof_i),
      .rx_eof_i   (rx_eof_i),
      .rx_data_i  (rx_data_i),
      .done_o     (f_done),
      .hdr_ok_o   (f_hdr_ok),
      .len_o      (f_len),
      .dest_o     (f_dest)
   );

   rxf_addr_match u_match (
      .filt_i    (filt_mode_i),
      .station_i (station_addr_i),
      .dest_i    (f_dest),
      .accept_o  (f_accept)
   );

   rxf_err_encode #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_enc (
      .len_i     (f_len),
      .overrun_i (rx_overrun_i),
      .crc_i     (rx_crc_err_i),
      .dribble_i (rx_dribble_i),
      .align_i   (rx_align_err_i),
      .stat_o    (f_stat)
   );

   assign q_push = f_done && f_hdr_ok && f_accept;

   rxf_stat_queue #(.DEPTH(DEPTH), .W(STAT_W), .LVL_W(LVL_W)) u_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (q_push),
      .push_data_i (f_stat),
      .pop_i       (discard_i),
      .head_o      (q_head),
      .empty_o     (q_empty),
      .level_o     (q_level)
   );

   assign status_o = q_empty ? STAT_EMPTY : q_head;

   // R13
   status_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_empty && q_push) |=> !status_o[15]);

   // R4
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f_done && f_hdr_ok && filt_mode_i[FB_PROMISC] && q_level < LVL_W'(DEPTH))
      |=> !status_o[15]);

   // R9
   empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_level == '0) |-> (status_o == 16'h8000));

endmodule

// File: tb/rx_addr_filter_stat_tb.sv
module rx_addr_filter_stat_tb_top;

   typedef struct packed {
      logic [3:0]  filt;
      logic [47:0] da;
      logic [11:0] len;
      logic [3:0]  errs;   // {overrun, crc, dribble, align}
      logic        acc;
      logic [15:0] stat;
   } vec_t;

   localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
   localparam logic [47:0] MC  = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
   localparam int NV = 16;

   localparam vec_t TBL [NV] = '{
      '{4'h1, STA,                  12'd64,   4'b0000, 1'b1, 16'h0040}, // R1
      '{4'h1, 48'h02_11_22_33_44_56, 12'd64,  4'b0000, 1'b0, 16'h8000}, // R5
      '{4'h2, MC,                   12'd100,  4'b0000, 1'b1, 16'h0064}, // R2
      '{4'h2, BC,                   12'd64,   4'b0000, 1'b0, 16'h8000}, // R2
      '{4'h4, BC,                   12'd60,   4'b0000, 1'b1, 16'h003C}, // R3
      '{4'h4, MC,                   12'd64,   4'b0000, 1'b0, 16'h8000}, // R3
      '{4'h8, 48'h0A_0B_0C_0D_0E_0F, 12'd70,  4'b0000, 1'b1, 16'h0046}, // R4
      '{4'h1, STA,                  12'd59,   4'b0000, 1'b1, 16'h583B}, // R7 runt
      '{4'h1, STA,                  12'd1515, 4'b0000, 1'b1, 16'h4DEB}, // R7 oversize
      '{4'h1, STA,                  12'd64,   4'b0110, 1'b1, 16'h6840}, // R8 crc over dribble
      '{4'h1, STA,                  12'd64,   4'b1100, 1'b1, 16'h4040}, // R8 overrun over crc
      '{4'h1, STA,                  12'd64,   4'b0011, 1'b1, 16'h6040}, // R8 align over dribble
      '{4'h1, STA,                  12'd1514, 4'b0010, 1'b1, 16'h55EA}, // R7 dribble
      '{4'h0, STA,                  12'd64,   4'b0000, 1'b0, 16'h8000}, // R5
      '{4'h1, STA,                  12'd40,   4'b0001, 1'b1, 16'h5828}, // R8 runt over align
      '{4'h8, STA,                  12'd2100, 4'b0000, 1'b1, 16'h4FFF}  // R6 saturation
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        e_ovr = 1'b0, e_crc = 1'b0, e_drib = 1'b0, e_align = 1'b0;
   logic [3:0]  filt = '0;
   logic        discard = 1'b0;
   logic [15:0] status;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rx_addr_filter_stat dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_valid_i     (rx_valid),
      .rx_sof_i       (rx_sof),
      .rx_eof_i       (rx_eof),
      .rx_data_i      (rx_data),
      .rx_overrun_i   (e_ovr),
      .rx_crc_err_i   (e_crc),
      .rx_dribble_i   (e_drib),
      .rx_align_err_i (e_align),
      .filt_mode_i    (filt),
      .station_addr_i (STA),
      .discard_i      (discard),
      .status_o       (status)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: status=%h expected=%h", req, act, exp);
      end
   endtask

   // drives one frame; with disc set, raises discard on the last byte
   task automatic send(input logic [47:0] da, input int len, input logic [3:0] errs,
                       input bit disc);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         rx_eof   = (i == len - 1);
         rx_data  = (i < 6) ? da[47-8*i -: 8] : 8'(i);
         {e_ovr, e_crc, e_drib, e_align} = (i == len - 1) ? errs : 4'b0000;
         discard  = disc && (i == len - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; discard = 1'b0;
      {e_ovr, e_crc, e_drib, e_align} = 4'b0000;
   endtask

   task automatic pop();
      @(negedge clk); discard = 1'b1;
      @(negedge clk); discard = 1'b0;
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      chk("R9 reset", status, 16'h8000);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (TBL[k]) begin
         filt = TBL[k].filt;
         send(TBL[k].da, int'(TBL[k].len), TBL[k].errs, 1'b0);
         // R13: word visible right after the end-byte edge
         chk($sformatf("R%0d vector %0d", TBL[k].acc ? 13 : 5, k), status, TBL[k].stat);
         if (TBL[k].acc) begin
            pop();
            chk("R10 pop to empty", status, 16'h8000);
         end
      end

      // R5 short frame with all-accept mode
      filt = 4'h8;
      send(STA, 5, 4'b0000, 1'b0);
      chk("R5 short frame", status, 16'h8000);

      // R10 discard on empty queue
      pop();
      chk("R10 empty discard", status, 16'h8000);

      // R11 fill beyond depth, R10 order
      for (int n = 0; n < 5; n++) send(BC, 61 + n, 4'b0000, 1'b0);
      for (int n = 0; n < 4; n++) begin
         chk("R10 order", status, 16'(61 + n));
         pop();
      end
      chk("R11 fifth dropped", status, 16'h8000);

      // R12 push and discard in the same cycle
      send(BC, 70, 4'b0000, 1'b0);
      chk("R12 setup", status, 16'h0046);
      send(BC, 71, 4'b0000, 1'b1);
      chk("R12 new head", status, 16'h0047);
      pop();
      chk("R12 single entry left", status, 16'h8000);

      // R13 not visible before the end-byte edge
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'hFF;
      chk("R13 before edge", status, 16'h8000);
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      chk("R5 one-byte frame", status, 16'h8000);
   endtask

   initial begin
      fork
         begin run_all(); finished = 1'b1; end
         begin repeat (150000) @(posedge clk); end
      join_any
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: status=%h expected=done", status);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule